// File: doc/BRIEF.md
# Boot Memory Remap Decoder

This block decodes the address of each system bus access and picks the memory target. The lowest 1 MB of the address space (0x0000_0000 to 0x000F_FFFF) is the boot window. Every master fetches its first instruction from address 0x0 after reset, so the window points at valid memory from the first access. Which memory the window reaches depends on two things. One is the level of a boot-select pin, captured while reset is held. The other is a remap bit that software sets, and each master has its own bit.

While a master's remap bit is 0, the window for that master reaches the on-chip ROM if the captured pin level was 1. It reaches the external memory on chip select 0 if the level was 0. Once software sets the master's remap bit, that master sees the first internal SRAM bank in the window, whatever the pin level. The ROM, chip select 0, the SRAM and a peripheral region also answer at their own fixed bases at all times.

The decode is combinational. For each access the block gives a one-hot target select, the byte offset inside that target, and a decode-error flag. A small write and read port holds the remap bits.

Top module: `boot_remap_decoder`

## Requirements
- R1: While rst_n is low, the block captures boot_sel_i, and every remap bit clears to 0. After reset, each master's boot window follows the captured level.
- R2: Take a valid access in the boot window by a master whose remap bit is 0, with captured level 1. The block asserts tgt_sel_o bit 0 (ROM), and tgt_ofs_o equals address bits 19:0.
- R3: Take the same access with captured level 0. The block asserts tgt_sel_o bit 1 (chip select 0), and tgt_ofs_o equals address bits 19:0.
- R4: Take a valid access in the boot window by a master whose remap bit is 1. The block asserts tgt_sel_o bit 2 (SRAM), and tgt_ofs_o equals address bits 19:0, for either captured level.
- R5: Each master's remap bit acts only on that master's accesses.
- R6: A change on boot_sel_i after reset has been released does not change any decode.
- R7: The fixed regions decode the same way under every remap and pin setting. They are: SRAM at 0x0030_0000 (1 MB), ROM at 0x0040_0000 (1 MB), chip select 0 at 0x1000_0000 (256 MB), and the peripheral region at 0xF000_0000 (256 MB, tgt_sel_o bit 3). Each selects its own bit, with offset equal to the address minus the region base.
- R8: A valid access outside every region asserts dec_err_o and drives tgt_sel_o to 0 and tgt_ofs_o to 0.
- R9: While acc_valid_i is low, tgt_sel_o is 0 and dec_err_o is 0.
- R10: With cfg_we_i high at a clock edge, the bit for master cfg_widx_i takes cfg_wbit_i, which can set or clear it. The new value shows on cfg_rbit_o for cfg_ridx_i = that master, and it steers that master's accesses from the next cycle on.
- R11: At most one bit of tgt_sel_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; boot_sel_i is captured while low |
| boot_sel_i | input | 1 | Boot-select pin: 1 selects ROM, 0 selects chip select 0 |
| acc_valid_i | input | 1 | Access strobe |
| acc_master_i | input | MIDX_W (2) | Index of the master making the access |
| acc_addr_i | input | 32 | Access address |
| tgt_sel_o | output | 4 | One-hot target: bit0 ROM, bit1 CS0, bit2 SRAM, bit3 peripherals |
| tgt_ofs_o | output | OFS_W (28) | Byte offset inside the selected target |
| dec_err_o | output | 1 | Valid access matched no region |
| cfg_we_i | input | 1 | Remap bit write enable |
| cfg_widx_i | input | MIDX_W (2) | Master whose remap bit is written |
| cfg_wbit_i | input | 1 | Value written to the remap bit |
| cfg_ridx_i | input | MIDX_W (2) | Master whose remap bit is read |
| cfg_rbit_o | output | 1 | Remap bit of master cfg_ridx_i |

## Verification
The bench resets the block with each pin level and then toggles the pin. A block that kept sampling the pin after reset would move the boot window from ROM to chip select 0 in the middle of a run.

It also sets the remap bit for one master and sends accesses from the other masters. A block that shared one remap bit, or that let the pin win over the remap bit, would send those accesses to the wrong target.

Addresses are chosen on both sides of each region edge, for example 0x000F_FFFF against 0x0010_0000 and 0x0FFF_FFFF against 0x1000_0000. A block with an off-by-one base or mask would select a target where it should raise a decode error, or would produce a wrong offset.

// File: rtl/remap_pkg.sv
// Package: shared constants for the boot remap decoder.
// Assumes a 32-bit byte address and four memory targets.
package remap_pkg;
    localparam int ADDR_W  = 32;
    localparam int N_TGT   = 4;
    // Position of each target in the one-hot select vector.
    localparam int T_ROM   = 0;
    localparam int T_CS0   = 1;
    localparam int T_SRAM  = 2;
    localparam int T_PERI  = 3;

    typedef logic [N_TGT-1:0] tgt_vec_t;

    // True when addr lies in the 2**aw byte window that starts at base.
    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input int aw);
        logic [ADDR_W-1:0] hi_mask;
        hi_mask = ~((32'h1 << aw) - 32'h1);
        return (addr & hi_mask) == (base & hi_mask);
    endfunction

    // The low aw bits of addr: the offset inside an aligned window.
    function automatic logic [ADDR_W-1:0] low_bits(input logic [ADDR_W-1:0] addr,
                                                   input int aw);
        return addr & ((32'h1 << aw) - 32'h1);
    endfunction
endpackage

// File: rtl/remap_bootsel_latch.sv
// Module: remap_bootsel_latch
// Holds the boot-select pin level. The register loads on every clock edge
// while reset is low, and holds once reset has been released.
// Assumes that rst_n is low for at least one clock edge.
module remap_bootsel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic boot_rom_o
);
    // Sample the pin only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_rom_o <= pin_i;
    end
endmodule

// File: rtl/remap_ctrl_regs.sv
// Module: remap_ctrl_regs
// Holds one remap bit for each master, with a write port, a read-back port
// and a lookup port for the master that is currently accessing the bus.
// An index at or above N_MASTERS is dropped on write and reads as 0.
module remap_ctrl_regs #(
    parameter int N_MASTERS = 4,
    parameter int MIDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MIDX_W-1:0] widx_i,
    input  logic              wbit_i,
    input  logic [MIDX_W-1:0] ridx_i,
    output logic              rbit_o,
    input  logic [MIDX_W-1:0] acc_idx_i,
    output logic              acc_bit_o,
    output logic [N_MASTERS-1:0] bits_o
);
    logic [N_MASTERS-1:0] remap_q;

    // One flop per master; write enable decoded by index.
    for (genvar m = 0; m < N_MASTERS; m++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                remap_q[m] <= 1'b0;
            else if (we_i && (int'(widx_i) == m))
                remap_q[m] <= wbit_i;
        end
    end

    // Read-back mux for software.
    always_comb begin
        rbit_o = 1'b0;
        for (int m = 0; m < N_MASTERS; m++)
            if (int'(ridx_i) == m) rbit_o = remap_q[m];
    end

    // Lookup mux for the accessing master.
    always_comb begin
        acc_bit_o = 1'b0;
        for (int m = 0; m < N_MASTERS; m++)
            if (int'(acc_idx_i) == m) acc_bit_o = remap_q[m];
    end

    assign bits_o = remap_q;
endmodule

// File: rtl/remap_addr_decoder.sv
// Module: remap_addr_decoder
// Combinational decode of one access into a one-hot target and an offset.
// The boot window is checked first and redirected. The fixed regions
// follow. A miss raises the error flag.
// Assumes that all windows are aligned to their size and do not overlap,
// and that the boot window is no larger than any boot target.
module remap_addr_decoder
    import remap_pkg::*;
#(
    parameter int              OFS_W     = 28,
    parameter int              BOOT_AW   = 20,
    parameter logic [31:0]     SRAM_BASE = 32'h0030_0000,
    parameter int              SRAM_AW   = 20,
    parameter logic [31:0]     ROM_BASE  = 32'h0040_0000,
    parameter int              ROM_AW    = 20,
    parameter logic [31:0]     CS0_BASE  = 32'h1000_0000,
    parameter int              CS0_AW    = 28,
    parameter logic [31:0]     PERI_BASE = 32'hF000_0000,
    parameter int              PERI_AW   = 28
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              remap_i,
    input  logic              boot_rom_i,
    output tgt_vec_t          sel_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic              err_o
);
    logic [ADDR_W-1:0] ofs_full;

    // Find the region and the offset, with the boot window checked first.
    always_comb begin
        sel_o    = '0;
        ofs_full = '0;
        err_o    = 1'b0;
        if (valid_i) begin
            if (in_window(addr_i, 32'h0, BOOT_AW)) begin
                ofs_full = low_bits(addr_i, BOOT_AW);
                if (remap_i)         sel_o[T_SRAM] = 1'b1;
                else if (boot_rom_i) sel_o[T_ROM]  = 1'b1;
                else                 sel_o[T_CS0]  = 1'b1;
            end else if (in_window(addr_i, SRAM_BASE, SRAM_AW)) begin
                sel_o[T_SRAM] = 1'b1;
                ofs_full      = low_bits(addr_i, SRAM_AW);
            end else if (in_window(addr_i, ROM_BASE, ROM_AW)) begin
                sel_o[T_ROM] = 1'b1;
                ofs_full     = low_bits(addr_i, ROM_AW);
            end else if (in_window(addr_i, CS0_BASE, CS0_AW)) begin
                sel_o[T_CS0] = 1'b1;
                ofs_full     = low_bits(addr_i, CS0_AW);
            end else if (in_window(addr_i, PERI_BASE, PERI_AW)) begin
                sel_o[T_PERI] = 1'b1;
                ofs_full      = low_bits(addr_i, PERI_AW);
            end else begin
                err_o = 1'b1;
            end
        end
    end

    assign ofs_o = ofs_full[OFS_W-1:0];

    logic unused_hi;
    assign unused_hi = ^ofs_full[ADDR_W-1:OFS_W];
endmodule

// File: rtl/boot_remap_decoder.sv
// Module: boot_remap_decoder (top)
// Decodes bus accesses for several masters. The lowest window goes to the
// ROM or to chip select 0, depending on the pin level captured in reset,
// or to the SRAM when the accessing master's remap bit is set.
// Assumes a synchronous active-low reset that is held for at least one edge.
module boot_remap_decoder
    import remap_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int OFS_W     = 28,
    localparam int MIDX_W   = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel_i,
    input  logic              acc_valid_i,
    input  logic [MIDX_W-1:0] acc_master_i,
    input  logic [31:0]       acc_addr_i,
    output logic [3:0]        tgt_sel_o,
    output logic [OFS_W-1:0]  tgt_ofs_o,
    output logic              dec_err_o,
    input  logic              cfg_we_i,
    input  logic [MIDX_W-1:0] cfg_widx_i,
    input  logic              cfg_wbit_i,
    input  logic [MIDX_W-1:0] cfg_ridx_i,
    output logic              cfg_rbit_o
);
    logic                 boot_rom;
    logic                 acc_remap;
    logic [N_MASTERS-1:0] remap_vec;

    remap_bootsel_latch u_boot (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (boot_sel_i),
        .boot_rom_o (boot_rom)
    );

    remap_ctrl_regs #(.N_MASTERS(N_MASTERS), .MIDX_W(MIDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .widx_i    (cfg_widx_i),
        .wbit_i    (cfg_wbit_i),
        .ridx_i    (cfg_ridx_i),
        .rbit_o    (cfg_rbit_o),
        .acc_idx_i (acc_master_i),
        .acc_bit_o (acc_remap),
        .bits_o    (remap_vec)
    );

    remap_addr_decoder #(.OFS_W(OFS_W)) u_dec (
        .valid_i    (acc_valid_i),
        .addr_i     (acc_addr_i),
        .remap_i    (acc_remap),
        .boot_rom_i (boot_rom),
        .sel_o      (tgt_sel_o),
        .ofs_o      (tgt_ofs_o),
        .err_o      (dec_err_o)
    );
endmodule

// File: rtl/boot_remap_checker.sv
// Module: boot_remap_checker
// Property checks bound to boot_remap_decoder.
module boot_remap_checker #(
    parameter int N_MASTERS = 4,
    parameter int MIDX_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 boot_sel_i,
    input logic                 acc_valid_i,
    input logic [MIDX_W-1:0]    acc_master_i,
    input logic [31:0]          acc_addr_i,
    input logic [3:0]           tgt_sel_o,
    input logic                 dec_err_o,
    input logic                 cfg_we_i,
    input logic [MIDX_W-1:0]    cfg_widx_i,
    input logic                 cfg_wbit_i,
    input logic                 boot_rom,
    input logic [N_MASTERS-1:0] remap_vec
);
    logic in_boot;
    assign in_boot = acc_valid_i && (acc_addr_i[31:20] == 12'h000);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel_o)); // R11
    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> (tgt_sel_o == 4'b0)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |-> (tgt_sel_o == 4'b0 && !dec_err_o)); // R9
    AST_PIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(boot_rom)); // R6
    AST_BOOT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_boot && !remap_vec[acc_master_i] && boot_rom) |-> tgt_sel_o == 4'b0001); // R2
    AST_BOOT_SRAM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_boot && remap_vec[acc_master_i]) |-> tgt_sel_o == 4'b0100); // R4
    AST_REMAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> remap_vec[$past(cfg_widx_i)] == $past(cfg_wbit_i)); // R10
endmodule

bind boot_remap_decoder boot_remap_checker #(.N_MASTERS(N_MASTERS), .MIDX_W(MIDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_sel_i   (boot_sel_i),
    .acc_valid_i  (acc_valid_i),
    .acc_master_i (acc_master_i),
    .acc_addr_i   (acc_addr_i),
    .tgt_sel_o    (tgt_sel_o),
    .dec_err_o    (dec_err_o),
    .cfg_we_i     (cfg_we_i),
    .cfg_widx_i   (cfg_widx_i),
    .cfg_wbit_i   (cfg_wbit_i),
    .boot_rom     (boot_rom),
    .remap_vec    (remap_vec)
);

// File: tb/tb_boot_remap_decoder.sv
module tb_boot_remap_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel_i = 1'b1;
    logic        acc_valid_i = 1'b0;
    logic [1:0]  acc_master_i = '0;
    logic [31:0] acc_addr_i = '0;
    logic [3:0]  tgt_sel_o;
    logic [27:0] tgt_ofs_o;
    logic        dec_err_o;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_widx_i = '0;
    logic        cfg_wbit_i = 1'b0;
    logic [1:0]  cfg_ridx_i = '0;
    logic        cfg_rbit_o;

    int n_chk = 0;
    int n_bad = 0;
    logic       mdl_rom;
    logic [3:0] mdl_remap;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_remap_decoder dut (.*);

    // Count a check and report a mismatch.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Reference decode, computed from the requirements.
    function automatic logic [32:0] ref_dec(input logic [1:0] m, input logic [31:0] a,
                                            input logic v);
        logic [3:0] s; logic [27:0] o; logic e;
        s = 0; o = 0; e = 0;
        if (v) begin
            if (a < 32'h0010_0000) begin
                o = a[27:0];
                s = mdl_remap[m] ? 4'b0100 : (mdl_rom ? 4'b0001 : 4'b0010);
            end else if (a >= 32'h0030_0000 && a < 32'h0040_0000) begin
                s = 4'b0100; o = 28'(a - 32'h0030_0000);
            end else if (a >= 32'h0040_0000 && a < 32'h0050_0000) begin
                s = 4'b0001; o = 28'(a - 32'h0040_0000);
            end else if (a >= 32'h1000_0000 && a < 32'h2000_0000) begin
                s = 4'b0010; o = 28'(a - 32'h1000_0000);
            end else if (a >= 32'hF000_0000) begin
                s = 4'b1000; o = 28'(a - 32'hF000_0000);
            end else e = 1;
        end
        return {e, s, o};
    endfunction

    // Apply one access at the falling edge and compare one time unit later.
    task automatic access(input string req, input logic [1:0] m, input logic [31:0] a,
                          input logic v);
        @(negedge clk);
        acc_valid_i = v; acc_master_i = m; acc_addr_i = a;
        #1;
        check(req, {31'b0, dec_err_o, tgt_sel_o, tgt_ofs_o}, {31'b0, ref_dec(m, a, v)});
    endtask

    // Write one remap bit through the register port.
    task automatic wr(input logic [1:0] m, input logic b);
        @(negedge clk);
        cfg_we_i = 1; cfg_widx_i = m; cfg_wbit_i = b;
        @(negedge clk);
        cfg_we_i = 0;
        mdl_remap[m] = b;
    endtask

    // Reset with a given pin level.
    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 0; boot_sel_i = pin; acc_valid_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        mdl_rom = pin; mdl_remap = '0;
    endtask

    // Pick an address near a region or in a gap.
    function automatic logic [31:0] pick_addr();
        case ($urandom_range(0, 6))
            0: return $urandom_range(0, 32'h000F_FFFF);
            1: return 32'h0030_0000 + $urandom_range(0, 32'hF_FFFF);
            2: return 32'h0040_0000 + $urandom_range(0, 32'hF_FFFF);
            3: return 32'h1000_0000 + $urandom_range(0, 32'h0FFF_FFFF);
            4: return 32'hF000_0000 + $urandom_range(0, 32'h0FFF_FFFF);
            5: return 32'h0010_0000 + $urandom_range(0, 32'h1F_FFFF);
            default: return $urandom();
        endcase
    endfunction

    initial begin
        void'($urandom(1234));
        mdl_rom = 1; mdl_remap = '0;
        // Reset with the pin high.
        do_reset(1'b1);
        for (int m = 0; m < 4; m++) begin
            cfg_ridx_i = 2'(m); #1;
            check("R1 remap bit clear", {63'b0, cfg_rbit_o}, 64'd0);
        end
        access("R2 rom boot", 0, 32'h0000_0000, 1);
        access("R2 rom boot top", 3, 32'h000F_FFFF, 1);
        access("R8 just above boot", 1, 32'h0010_0000, 1);
        access("R9 idle", 2, 32'h0000_0040, 0);
        // Toggle the pin after reset.
        @(negedge clk); boot_sel_i = 0;
        repeat (2) @(negedge clk);
        access("R6 pin ignored", 0, 32'h0000_1234, 1);
        // Remap master 2 only.
        wr(2, 1);
        cfg_ridx_i = 2; #1;
        check("R10 readback set", {63'b0, cfg_rbit_o}, 64'd1);
        access("R4 remap sram", 2, 32'h0000_0ABC, 1);
        access("R5 other master", 1, 32'h0000_0ABC, 1);
        access("R7 rom base under remap", 2, 32'h0040_0010, 1);
        access("R7 sram edge", 0, 32'h003F_FFFF, 1);
        access("R8 gap below cs0", 0, 32'h0FFF_FFFF, 1);
        access("R7 cs0 base", 3, 32'h1000_0000, 1);
        access("R7 peri top", 1, 32'hFFFF_FFFF, 1);
        wr(2, 0);
        check("R10 readback clear", {63'b0, cfg_rbit_o}, 64'd0);
        access("R10 clear steers", 2, 32'h0000_0ABC, 1);
        // Reset with the pin low.
        do_reset(1'b0);
        access("R3 cs0 boot", 0, 32'h0008_0000, 1);
        access("R1 reset clears remap", 2, 32'h0000_0010, 1);
        @(negedge clk); boot_sel_i = 1;
        access("R6 pin ignored high", 1, 32'h0000_0020, 1);
        wr(0, 1);
        access("R4 remap beats pin", 0, 32'h000F_FFF0, 1);
        // Random mix of writes and accesses.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0) wr(2'($urandom_range(0, 3)), 1'($urandom()));
            access("R11 random", 2'($urandom_range(0, 3)), pick_addr(),
                   $urandom_range(0, 9) != 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule